// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host reach an external asynchronous static RAM of 16-bit words. The host offers one request at a time on a valid/ready port. Each request carries an address, a write flag, a two-bit lane mask and write data. The controller turns each request into a strobe sequence whose phase lengths meet the RAM's nanosecond minimums. Every phase length is a whole number of clock cycles, computed by rounding up the quotient of a nanosecond limit by the clock period.

Reads return the captured word with a single-cycle valid pulse. Lanes that are masked off read as zero. Writes update only the enabled byte lanes. A write always ends with write enable rising on its own, while select, lanes and data stay put for one more cycle. The data bus is split into an output word, a drive enable and an input word, so the pad tristate can live outside the block. When a read directly follows a write, one quiet cycle is placed between them so that the two bus directions never overlap.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the device is deselected and the bus is idle: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_lb_n`=1, `mem_ub_n`=1, `mem_dq_drive`=0 and `rsp_valid`=0.
- R2: A read holds the selects and output enable, and keeps the address stable, for RD = max(ceil(tAA/Tclk), ceil(tRC/Tclk)) cycles. The word on `mem_dq_in` is captured at the end of the last of those cycles. `rsp_valid` rises RD+1 cycles after the accepting edge, or RD+2 cycles when the turnaround cycle of R9 applies.
- R3: A write holds `mem_we_n` low for WE = max(ceil(40 ns/Tclk), ceil(45 ns/Tclk), ceil(25 ns/Tclk)) cycles. Selects, address, lanes and write data are active and unchanged for the whole pulse.
- R4: A write ends with `mem_we_n` rising while both selects and the lanes stay active and the data is still driven. `req_ready` returns max(WE+1, ceil(tWC/Tclk)) + 1 cycles after the accepting edge.
- R5: Mask bit 0 enables the low lane (`mem_lb_n` low, data bits 7:0). Mask bit 1 enables the high lane (`mem_ub_n` low, bits 15:8). A write changes only the enabled lanes of the stored word.
- R6: In `rsp_rdata`, a lane whose mask bit is 0 reads as 8'h00. An enabled lane carries the device word.
- R7: A request with mask 2'b00 asserts neither lane enable, so the device is deselected and such a write leaves the stored word unchanged.
- R8: `mem_dq_drive` is high only while `mem_we_n` is low and during the single cycle after it rises. `mem_oe_n` is high whenever `mem_we_n` is low or the bus is driven.
- R9: A read that follows a write gets one extra cycle with all strobes inactive before output enable falls. A read after a read, or the first read after reset, gets none.
- R10: `req_ready` is high only when the controller is idle, and a request is taken only on a clock edge where both `req_valid` and `req_ready` are high. Fields presented while busy are ignored.
- R11: `rsp_valid` is high for exactly one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | ADDR_W | Device address |
| mem_dq_out | output | 16 | Data toward the device |
| mem_dq_drive | output | 1 | Enable for the data pad drivers |
| mem_dq_in | input | 16 | Data from the device pads |
| mem_cs_n | output | 1 | Active-low select |
| mem_cs | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |

## Verification
The bench builds the controller with a 4-bit address and the default nanosecond limits at a 5000 ps clock. This gives 11-cycle reads, 9-cycle write pulses and 11-cycle write cycles. The small address space lets every word be written under every lane mask and read back under both full and partial masks, with read-after-write and read-after-read orderings alternating throughout. The bench's RAM model drives valid data only once the access time has elapsed and stores data only on the terminating edge, so an early capture, a short pulse or a missing hold cycle shows up directly in the returned data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANES  = 2;
    localparam int unsigned LANE_W = DATA_W / LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_RD_ACC,
        ST_RD_RESP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic drive;
        logic rsp;
    } strobe_t;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC   = 11,
    parameter int unsigned WE_CYC   = 9,
    parameter int unsigned HOLD_CYC = 2,
    parameter int unsigned CNT_W    = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    start_wr,
    output logic    idle,
    output logic    capture,
    output strobe_t stb
);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             wr_tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            wr_tail <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        if (start_wr)     state <= ST_WR_PULSE;
                        else if (wr_tail) state <= ST_TURN;
                        else              state <= ST_RD_ACC;
                    end
                end
                ST_TURN: begin
                    state   <= ST_RD_ACC;
                    wr_tail <= 1'b0;
                end
                ST_RD_ACC: begin
                    if (cnt == CNT_W'(RD_CYC - 1)) begin
                        state <= ST_RD_RESP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RD_RESP: state <= ST_IDLE;
                ST_WR_PULSE: begin
                    if (cnt == CNT_W'(WE_CYC - 1)) begin
                        state <= ST_WR_HOLD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WR_HOLD: begin
                    if (cnt == CNT_W'(HOLD_CYC - 1)) begin
                        state   <= ST_IDLE;
                        cnt     <= '0;
                        wr_tail <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle      = (state == ST_IDLE);
        capture   = (state == ST_RD_ACC) && (cnt == CNT_W'(RD_CYC - 1));
        stb.sel   = (state == ST_RD_ACC) || (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
        stb.oe    = (state == ST_RD_ACC);
        stb.we    = (state == ST_WR_PULSE);
        stb.drive = (state == ST_WR_PULSE) || ((state == ST_WR_HOLD) && (cnt == '0));
        stb.rsp   = (state == ST_RD_RESP);
    end

endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes
    import sram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  mask,
    input  logic              sel,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  be_n,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_n[g] = !(sel && mask[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[g*LANE_W +: LANE_W] <= mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 17,
    parameter int unsigned CLK_PS  = 5000,
    parameter int unsigned T_RC_NS = 55,
    parameter int unsigned T_AA_NS = 55,
    parameter int unsigned T_WC_NS = 55,
    parameter int unsigned T_WP_NS = 40,
    parameter int unsigned T_AW_NS = 45,
    parameter int unsigned T_SW_NS = 45,
    parameter int unsigned T_DS_NS = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_mask,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [15:0]       mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n
);

    localparam int unsigned RD_CYC = max2(ns_to_cyc(T_AA_NS, CLK_PS), ns_to_cyc(T_RC_NS, CLK_PS));
    localparam int unsigned WE_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_PS), ns_to_cyc(T_AW_NS, CLK_PS)),
                                          max2(ns_to_cyc(T_SW_NS, CLK_PS), ns_to_cyc(T_DS_NS, CLK_PS)));
    localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_PS);
    localparam int unsigned HOLD_CYC = (WC_CYC > WE_CYC + 1) ? (WC_CYC - WE_CYC) : 1;
    localparam int unsigned CNT_W    = $clog2(max2(max2(RD_CYC, WE_CYC), HOLD_CYC) + 1);

    req_t              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic              idle;
    logic              capture;
    logic              accept;
    strobe_t           stb;
    logic [LANES-1:0]  be_n;

    assign accept = req_valid && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            req_q  <= '{write: req_write, mask: req_mask, wdata: req_wdata};
            addr_q <= req_addr;
        end
    end

    sram_ctrl_seq #(
        .RD_CYC  (RD_CYC),
        .WE_CYC  (WE_CYC),
        .HOLD_CYC(HOLD_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .start_wr(req_write),
        .idle    (idle),
        .capture (capture),
        .stb     (stb)
    );

    sram_ctrl_lanes u_lanes (
        .clk    (clk),
        .rst    (rst),
        .mask   (req_q.mask),
        .sel    (stb.sel),
        .capture(capture),
        .dq_in  (mem_dq_in),
        .be_n   (be_n),
        .rdata  (rsp_rdata)
    );

    assign req_ready    = idle;
    assign rsp_valid    = stb.rsp;
    assign mem_addr     = addr_q;
    assign mem_dq_out   = req_q.wdata;
    assign mem_dq_drive = stb.drive;
    assign mem_cs_n     = !stb.sel;
    assign mem_cs       = stb.sel;
    assign mem_oe_n     = !stb.oe;
    assign mem_we_n     = !stb.we;
    assign mem_lb_n     = be_n[0];
    assign mem_ub_n     = be_n[1];

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int unsigned AW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic [15:0]   mem_dq_out,
    input logic          mem_dq_drive,
    input logic          mem_cs_n,
    input logic          mem_cs,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_lb_n,
    input logic          mem_ub_n
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_drive && !rsp_valid));

    a_r3_pulse_steady: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)
                                           && $stable(mem_lb_n) && $stable(mem_ub_n)));

    a_r4_we_ends_alone: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_cs && mem_dq_drive
                             && $stable(mem_lb_n) && $stable(mem_ub_n) && $stable(mem_addr)));

    a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || mem_dq_drive) |-> mem_oe_n);

    a_r8_drive_window: assert property (@(posedge clk) disable iff (rst)
        mem_dq_drive |-> (!mem_we_n || $past(!mem_we_n)));

    a_r9_quiet_before_read: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> ($past(mem_cs_n) && $past(mem_cs_n, 2)));

    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .mem_addr    (mem_addr),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_drive(mem_dq_drive),
    .mem_cs_n    (mem_cs_n),
    .mem_cs      (mem_cs),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_lb_n    (mem_lb_n),
    .mem_ub_n    (mem_ub_n)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;

    localparam int AW      = 4;
    localparam int DEPTH   = 1 << AW;
    localparam int EXP_RD  = (55 + 4) / 5;
    localparam int EXP_WE  = (45 + 4) / 5;
    localparam int EXP_WC  = (55 + 4) / 5;
    localparam int EXP_WBUSY = ((EXP_WE + 1 > EXP_WC) ? EXP_WE + 1 : EXP_WC) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [1:0]    req_mask = 2'b00;
    logic [15:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dq_out;
    logic          mem_dq_drive;
    logic [15:0]   mem_dq_in;
    logic          mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    sram_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_mask(req_mask), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
        .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
    );

    function automatic void check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // RAM model: stores on the terminating edge, drives data only after access time
    logic [15:0]   mdl_mem [DEPTH];
    logic [15:0]   shadow  [DEPTH];
    logic          prev_wact = 1'b0;
    logic [1:0]    p_lanes = 2'b00;
    logic [AW-1:0] p_addr = '0;
    logic [AW-1:0] r_addr = '0;
    int            we_w = 0;
    int            last_we_w = 0;
    int            rd_cnt = 0;
    logic          sel, ract;

    assign sel  = !mem_cs_n && mem_cs;
    assign ract = sel && !mem_oe_n && mem_we_n;

    always_comb begin
        mem_dq_in = 16'hDEAD;
        if (ract && rd_cnt >= EXP_RD) begin
            mem_dq_in[7:0]  = mem_lb_n ? 8'hA5 : mdl_mem[mem_addr][7:0];
            mem_dq_in[15:8] = mem_ub_n ? 8'h5A : mdl_mem[mem_addr][15:8];
        end
    end

    always @(negedge clk) begin
        logic wact;
        wact = sel && !mem_we_n && (!mem_lb_n || !mem_ub_n);
        if (wact) begin
            if (prev_wact && mem_addr != p_addr) check(1'b0, "R3 address moved in pulse", int'(mem_addr), int'(p_addr));
            we_w++;
            p_addr  = mem_addr;
            p_lanes = {!mem_ub_n, !mem_lb_n};
        end else if (prev_wact) begin
            last_we_w = we_w;
            we_w = 0;
            check(mem_dq_drive && sel, "R4 data/select at write end", {mem_dq_drive, sel}, 3);
            if (p_lanes[0]) mdl_mem[p_addr][7:0]  = mem_dq_out[7:0];
            if (p_lanes[1]) mdl_mem[p_addr][15:8] = mem_dq_out[15:8];
        end
        prev_wact = wact;
        if (ract) begin
            rd_cnt = (rd_cnt != 0 && mem_addr == r_addr) ? rd_cnt + 1 : 1;
            r_addr = mem_addr;
        end else begin
            rd_cnt = 0;
        end
    end

    function automatic logic [15:0] pat(input int a, input int k);
        return 16'((a * 16'h1357) ^ (k * 16'h2468) ^ 16'hC3A5);
    endfunction

    bit last_was_wr = 1'b0;

    task automatic do_write(input int a, input logic [1:0] m, input logic [15:0] d, input bit jam);
        int n;
        bit busy_ok;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_mask = m; req_wdata = d;
        n = 0;
        busy_ok = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (jam) begin
                req_addr = AW'(a + 1); req_wdata = 16'hFFFF; req_mask = 2'b11;
            end else begin
                req_valid = 1'b0;
            end
            if (req_ready || n > 100) break;
        end
        req_valid = 1'b0;
        check(n == EXP_WBUSY, "R4 write busy length", n, EXP_WBUSY);
        if (m != 2'b00) check(last_we_w == EXP_WE, "R3 write pulse width", last_we_w, EXP_WE);
        if (m[0]) shadow[a][7:0]  = d[7:0];
        if (m[1]) shadow[a][15:8] = d[15:8];
        last_was_wr = 1'b1;
    endtask

    task automatic do_read(input int a, input logic [1:0] m);
        int n, exp_n;
        logic [15:0] exp_d;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_mask = m;
        exp_n = EXP_RD + 1 + (last_was_wr ? 1 : 0);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            req_valid = 1'b0;
            if (rsp_valid || n > 100) break;
            check(!req_ready, "R10 ready low while busy", int'(req_ready), 0);
        end
        check(n == exp_n, last_was_wr ? "R9 read latency after write" : "R2 read latency", n, exp_n);
        exp_d = {m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00};
        check(rsp_rdata == exp_d, (m == 2'b11) ? "R5 read data" : "R6 masked read data",
              int'(rsp_rdata), int'(exp_d));
        @(negedge clk);
        check(!rsp_valid, "R11 single response pulse", int'(rsp_valid), 0);
        last_was_wr = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mdl_mem[i] = 16'h0000;
            shadow[i]  = 16'h0000;
        end
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !rsp_valid, "R1 ready after reset", {req_ready, rsp_valid}, 2);
        check({mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_drive} == 7'b1011110,
              "R1 strobes idle", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_drive}, 7'b1011110);

        // R2 first read after reset: no turnaround
        do_read(0, 2'b11);

        for (int a = 0; a < DEPTH; a++) do_write(a, 2'b11, pat(a, 0), 1'b0);
        for (int a = 0; a < DEPTH; a++) do_read(a, 2'b11);

        // R5 R6 R7 lane sweep: every address under every mask
        for (int a = 0; a < DEPTH; a++) begin
            for (int m = 0; m < 4; m++) begin
                do_write(a, 2'(m), pat(a, m + 1), 1'b0);
                do_read(a, (m == 0) ? 2'b11 : 2'(m));
                do_read(a, 2'b11);
            end
        end

        // R7 explicit: mask 00 write leaves word intact
        do_write(3, 2'b00, 16'h0000, 1'b0);
        do_read(3, 2'b11);

        // R10 fields changed while busy are ignored
        do_write(5, 2'b11, 16'h1234, 1'b1);
        do_read(5, 2'b11);
        do_read(6, 2'b11);
        @(negedge clk);
        check(req_ready && mem_cs_n, "R1 idle at end", {req_ready, mem_cs_n}, 3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule